// File: doc/BRIEF.md
# Register Block Transfer Unit

This unit moves a run of general-purpose byte registers between a 16-entry register file and byte-wide memory. One command names a direction, a last-register index `x` and a starting memory address. A store copies registers 0 through `x` to memory at that address and the bytes that follow it. A load fills registers 0 through `x` from the same kind of memory window. The register file and the memory stay outside the unit. The unit drives their ports and keeps the running address in its own register.

The starting address sits in a 16-bit index register. It advances by one for every byte moved. When the command ends it is left pointing just past the last byte, and it is not put back. A command is taken only while the unit is idle. `busy_o` covers the whole transfer, and `done_o` marks the first idle cycle with a single-cycle pulse. Memory reads return data one cycle after the request. During a load, the unit therefore requests the next byte in the same cycle that it writes the previous byte into the register file.

Top module: `regblk_xfer`

## Requirements
- R1: Store (`dir_i` = 0). Register k goes to memory address I+k for k = 0 to `x`, in rising k order. One byte is written per cycle on the cycles that follow the accepting edge.
- R2: Load (`dir_i` = 1). The memory byte at I+k goes into register k for k = 0 to `x`, in rising k order.
- R3: Both ends of the range are included, so `x` = 0 moves exactly one byte. No memory byte past I+`x` is written, and no register above `x` is written.
- R4: `i_addr_o` steps by one after each byte, as a full 16-bit add with carry into the upper byte and wrap from FFFF to 0000. On completion it equals the start address plus `x`+1, and it holds there while idle.
- R5: `busy_o` is high for `x`+1 cycles on a store and `x`+2 cycles on a load, starting in the cycle after the accepting edge. `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls. A command given in that cycle is accepted.
- R6: `start_i` has no effect while `busy_o` is high. The running command keeps its direction, range and address.
- R7: A memory read issued in one cycle is consumed from `mem_rdata_i` in the next cycle. That is the cycle in which the register write for that byte happens.
- R8: After reset, `busy_o`, `done_o` and all write and read strobes are low, and `i_addr_o` is 0000. No strobe rises while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request, taken when idle |
| dir_i | input | 1 | 0 = store registers to memory, 1 = load registers from memory |
| x_i | input | 4 | Index of the last register in the range |
| i_addr_i | input | 16 | Starting memory address |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| i_addr_o | output | 16 | Current index address |
| rf_idx_o | output | 4 | Register file index |
| rf_we_o | output | 1 | Register file write strobe |
| rf_wdata_o | output | 8 | Register file write data |
| rf_rdata_i | input | 8 | Register file read data, combinational on `rf_idx_o` |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data, one cycle after `mem_re_o` |

## Verification
Two kinds of overlap can occur in one cycle.

The first is inside a load. The register write for byte k happens in the same cycle as the memory read request for byte k+1. Loads of several lengths with distinct byte patterns exercise this, and the bench compares every register against the memory byte at its own offset. A slip by one in the write index or in the read-data timing would place a wrong byte in some register.

The second is at the boundary between two commands. A completion pulse and a new command's acceptance can fall in the same cycle. The bench raises `start_i` in the very cycle it sees `done_o`, then checks that `busy_o` rises on the next cycle and that the second command moves the correct bytes.

// File: rtl/regblk_pkg.sv
package regblk_pkg;
  typedef enum logic {
    XFER_STORE = 1'b0,
    XFER_LOAD  = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/regblk_ctrl.sv
module regblk_ctrl
  import regblk_pkg::*;
#(
  parameter int NREG  = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  xfer_dir_e        dir_i,
  input  logic [IDX_W-1:0] x_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o,
  output xfer_dir_e        dir_o,
  output logic             issue_o,
  output logic [IDX_W-1:0] issue_idx_o,
  output logic             wb_valid_o,
  output logic [IDX_W-1:0] wb_idx_o
);
  logic             busy_q, done_q, issue_on_q, wb_valid_q;
  xfer_dir_e        dir_q;
  logic [IDX_W-1:0] x_q, cnt_q, wb_idx_q;
  logic             last, done_set;

  assign accept_o = start_i & ~busy_q;
  assign issue_o  = busy_q & issue_on_q;
  // termination: compare index with x before advancing
  assign last     = (cnt_q == x_q);
  assign done_set = busy_q & (((dir_q == XFER_STORE) & issue_o & last) |
                              ((dir_q == XFER_LOAD) & wb_valid_q & ~issue_on_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      issue_on_q <= 1'b0;
      wb_valid_q <= 1'b0;
      dir_q      <= XFER_STORE;
      x_q        <= '0;
      cnt_q      <= '0;
      wb_idx_q   <= '0;
    end else begin
      done_q     <= done_set;
      wb_valid_q <= issue_o & (dir_q == XFER_LOAD);
      wb_idx_q   <= cnt_q;
      if (accept_o) begin
        busy_q     <= 1'b1;
        dir_q      <= dir_i;
        x_q        <= x_i;
        cnt_q      <= '0;
        issue_on_q <= 1'b1;
      end else begin
        if (issue_o) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) issue_on_q <= 1'b0;
        end
        if (done_set) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign dir_o       = dir_q;
  assign issue_idx_o = cnt_q;
  assign wb_valid_o  = wb_valid_q;
  assign wb_idx_o    = wb_idx_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R5
  AST_WB_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_q |-> (wb_idx_q <= x_q)); // R3
  AST_ISSUE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (cnt_q <= x_q)); // R3
endmodule

// File: rtl/regblk_addr.sv
module regblk_addr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] i_q;

  // full-width increment, carry runs into the upper byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     i_q <= '0;
    else if (load_i) i_q <= base_i;
    else if (step_i) i_q <= i_q + 1'b1;
  end

  assign addr_o = i_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(i_q)); // R4
endmodule

// File: rtl/regblk_port.sv
module regblk_port
  import regblk_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  xfer_dir_e         dir_i,
  input  logic              issue_i,
  input  logic [IDX_W-1:0]  issue_idx_i,
  input  logic              wb_valid_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [ADDR_W-1:0] i_addr_i,
  input  logic [DATA_W-1:0] rf_rdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic              rf_we_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_re_o
);
  logic is_load;
  assign is_load = (dir_i == XFER_LOAD);

  always_comb begin
    rf_idx_o    = is_load ? wb_idx_i : issue_idx_i;
    rf_we_o     = wb_valid_i;
    rf_wdata_o  = mem_rdata_i;
    mem_addr_o  = i_addr_i;
    mem_we_o    = issue_i & ~is_load;
    mem_wdata_o = rf_rdata_i;
    mem_re_o    = issue_i & is_load;
  end
endmodule

// File: rtl/regblk_xfer.sv
module regblk_xfer
  import regblk_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [IDX_W-1:0]  x_i,
  input  logic [ADDR_W-1:0] i_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] i_addr_o,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic              rf_we_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic             accept, issue, wb_valid;
  logic [IDX_W-1:0] issue_idx, wb_idx;
  xfer_dir_e        run_dir;

  regblk_ctrl #(.NREG(NREG)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dir_i      (xfer_dir_e'(dir_i)),
    .x_i        (x_i),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .dir_o      (run_dir),
    .issue_o    (issue),
    .issue_idx_o(issue_idx),
    .wb_valid_o (wb_valid),
    .wb_idx_o   (wb_idx)
  );

  regblk_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .base_i(i_addr_i),
    .step_i(issue),
    .addr_o(i_addr_o)
  );

  regblk_port #(.NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
    .dir_i      (run_dir),
    .issue_i    (issue),
    .issue_idx_i(issue_idx),
    .wb_valid_i (wb_valid),
    .wb_idx_i   (wb_idx),
    .i_addr_i   (i_addr_o),
    .rf_rdata_i (rf_rdata_i),
    .mem_rdata_i(mem_rdata_i),
    .rf_idx_o   (rf_idx_o),
    .rf_we_o    (rf_we_o),
    .rf_wdata_o (rf_wdata_o),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_re_o   (mem_re_o)
  );

  AST_WB_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> $past(mem_re_o)); // R7
  AST_I_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |=> (i_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_we_o || mem_re_o || rf_we_o)); // R8
  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(busy_o)); // R5
  AST_NO_START_MIDRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R6
  AST_ONE_MEM_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o)); // R1
endmodule

// File: tb/regblk_xfer_test.sv
module regblk_xfer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        dir_i = 1'b0;
  logic [3:0]  x_i = '0;
  logic [15:0] i_addr_i = '0;
  logic        busy_o, done_o, rf_we_o, mem_we_o, mem_re_o;
  logic [15:0] i_addr_o, mem_addr_o;
  logic [3:0]  rf_idx_o;
  logic [7:0]  rf_wdata_o, rf_rdata_i, mem_wdata_o, mem_rdata_i;

  logic [7:0]  rf_m [16];
  logic [7:0]  mem_m [256];
  logic [7:0]  mem_rd_q;
  logic        pre_rf_we = 1'b0, pre_mem_we = 1'b0;
  logic [3:0]  pre_rf_idx = '0;
  logic [7:0]  pre_mem_idx = '0, pre_data = '0;

  int n_total = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  regblk_xfer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .dir_i(dir_i), .x_i(x_i),
    .i_addr_i(i_addr_i), .busy_o(busy_o), .done_o(done_o), .i_addr_o(i_addr_o),
    .rf_idx_o(rf_idx_o), .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o),
    .rf_rdata_i(rf_rdata_i), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i)
  );

  assign rf_rdata_i  = rf_m[rf_idx_o];
  assign mem_rdata_i = mem_rd_q;

  always @(posedge clk) begin
    if (pre_rf_we)  rf_m[pre_rf_idx]    <= pre_data;
    if (pre_mem_we) mem_m[pre_mem_idx]  <= pre_data;
    if (rf_we_o)    rf_m[rf_idx_o]      <= rf_wdata_o;
    if (mem_we_o)   mem_m[mem_addr_o[7:0]] <= mem_wdata_o;
    if (mem_re_o)   mem_rd_q <= mem_m[mem_addr_o[7:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input logic [7:0] seed);
    return 8'(seed + k * 37);
  endfunction

  task automatic fill_rf(input logic [7:0] seed);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); pre_rf_we = 1'b1; pre_rf_idx = 4'(k); pre_data = pat(k, seed);
    end
    @(negedge clk); pre_rf_we = 1'b0;
  endtask

  task automatic fill_mem(input logic [7:0] seed);
    for (int k = 0; k < 256; k++) begin
      @(negedge clk); pre_mem_we = 1'b1; pre_mem_idx = 8'(k); pre_data = pat(k, seed);
    end
    @(negedge clk); pre_mem_we = 1'b0;
  endtask

  // drives a command, returns at the negedge where done_o is seen
  task automatic run_cmd(input bit ld, input logic [3:0] x, input logic [15:0] a,
                         output int busy_n);
    @(negedge clk); start_i = 1'b1; dir_i = ld; x_i = x; i_addr_i = a;
    @(negedge clk); start_i = 1'b0;
    busy_n = 0;
    while (!done_o && busy_n < 100) begin
      if (busy_o) busy_n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R8 busy", 32'(busy_o), 0);
    chk("R8 done", 32'(done_o), 0);
    chk("R8 iaddr", 32'(i_addr_o), 0);
    chk("R8 strobes", 32'({mem_we_o, mem_re_o, rf_we_o}), 0);
  endtask

  task automatic t_store(input logic [3:0] x, input logic [15:0] a, input logic [7:0] seed);
    int bn;
    logic [7:0] sent;
    fill_rf(seed);
    fill_mem(8'h5A);
    sent = pat(int'(8'(a + 16'(x) + 16'd1)), 8'h5A);
    run_cmd(1'b0, x, a, bn);
    for (int k = 0; k <= int'(x); k++)
      chk("R1 store byte", 32'(mem_m[8'(a + 16'(k))]), 32'(pat(k, seed)));
    chk("R3 store no overrun", 32'(mem_m[8'(a + 16'(x) + 16'd1)]), 32'(sent));
    chk("R4 final I", 32'(i_addr_o), 32'(16'(a + 16'(x) + 16'd1)));
    chk("R5 store busy cycles", 32'(bn), 32'(int'(x) + 1));
    @(negedge clk);
    chk("R5 done one cycle", 32'(done_o), 0);
    chk("R4 I holds idle", 32'(i_addr_o), 32'(16'(a + 16'(x) + 16'd1)));
  endtask

  task automatic t_load(input logic [3:0] x, input logic [15:0] a, input logic [7:0] seed);
    int bn;
    fill_mem(seed);
    fill_rf(8'hE1);
    run_cmd(1'b1, x, a, bn);
    for (int k = 0; k <= int'(x); k++)
      chk("R2 R7 load byte", 32'(rf_m[k]), 32'(pat(int'(8'(a + 16'(k))), seed)));
    if (x != 4'hF)
      chk("R3 load no overrun", 32'(rf_m[int'(x) + 1]), 32'(pat(int'(x) + 1, 8'hE1)));
    chk("R4 final I", 32'(i_addr_o), 32'(16'(a + 16'(x) + 16'd1)));
    chk("R5 load busy cycles", 32'(bn), 32'(int'(x) + 2));
  endtask

  task automatic t_busy_ignore;
    int bn;
    fill_rf(8'h13);
    fill_mem(8'h77);
    @(negedge clk); start_i = 1'b1; dir_i = 1'b0; x_i = 4'd5; i_addr_i = 16'h0040;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); start_i = 1'b1; dir_i = 1'b1; x_i = 4'd1; i_addr_i = 16'h0080;
    @(negedge clk); start_i = 1'b0;
    bn = 0;
    while (!done_o && bn < 100) begin @(negedge clk); bn++; end
    chk("R6 I from first cmd", 32'(i_addr_o), 32'h0046);
    chk("R6 rf0 untouched", 32'(rf_m[0]), 32'(pat(0, 8'h13)));
    chk("R6 store range kept", 32'(mem_m[8'h45]), 32'(pat(5, 8'h13)));
    // R5: new command in the done cycle is accepted
    start_i = 1'b1; dir_i = 1'b1; x_i = 4'd2; i_addr_i = 16'h0040;
    @(negedge clk); start_i = 1'b0;
    chk("R5 accept in done cycle", 32'(busy_o), 1);
    bn = 0;
    while (!done_o && bn < 100) begin @(negedge clk); bn++; end
    chk("R5 back-to-back load", 32'(rf_m[2]), 32'(pat(2, 8'h13)));
    chk("R4 back-to-back I", 32'(i_addr_o), 32'h0043);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store(4'd0, 16'h0010, 8'h21);
    t_store(4'd15, 16'h0020, 8'h03);
    t_store(4'd3, 16'h00FE, 8'h9C);
    t_load(4'd7, 16'h0030, 8'h44);
    t_load(4'd0, 16'h0050, 8'hB2);
    t_load(4'd15, 16'hFFF8, 8'h6D);
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule